// File: doc/BRIEF.md
# Ethernet PAUSE Frame Generator

This block produces a complete 802.3 flow-control PAUSE frame as a stream of bytes whenever it is asked to. A single-cycle request, sampled together with the station's own 48-bit address and a 16-bit pause duration, starts a 64-byte frame. The pause duration is counted in units of 512 bit-times. The frame carries a fixed layout:

- the reserved multicast destination;
- the source address;
- the MAC Control type and the PAUSE opcode;
- the pause duration;
- zero fill;
- a CRC-32 check sequence that the block computes while the bytes go out.

The byte stream uses a valid/ready handshake with a last marker on the final byte. A receive-side congestion monitor would typically drive the request: a long pause duration when its buffer fills past a high mark, and a zero duration when the buffer drains below a low mark. Preamble, start delimiter and gap timing are left to the downstream MAC.

Top module: `pause_frame_gen`

## Requirements
- R1: While reset is asserted, and right after it, `tx_valid_o` and `tx_last_o` are low, including when reset hits in the middle of a frame.
- R2: Frame bytes 0 to 5 are the destination address 01, 80, C2, 00, 00, 01, in that order.
- R3: Frame bytes 6 to 11 are the captured source address, most significant byte (bits 47:40) first.
- R4: Bytes 12 and 13 are 88 then 08 (the control type), and bytes 14 and 15 are 00 then 01 (the PAUSE opcode).
- R5: Bytes 16 and 17 are the captured pause duration, high byte first.
- R6: Bytes 18 through 59 are all zero.
- R7: Bytes 60 to 63 are the check sequence, sent low byte first. It is a CRC-32 over bytes 0 to 59 using the reflected polynomial 0xEDB88320, a start value of all ones and an inverted final value.
- R8: A frame is exactly 64 transfers, and `tx_last_o` is high on the byte at index 63 and on no other transfer.
- R9: A byte moves only on a cycle where valid and ready are both high. While valid is high and ready is low, the data and last outputs hold, and valid stays high.
- R10: A request that arrives during a frame is remembered, and any number of such requests merge into one. The next frame then starts in the cycle right after the last byte of the current frame has been accepted.
- R11: The address and duration are captured only when a frame starts. Changes on those inputs during a frame do not alter it.
- R12: A request while idle raises `tx_valid_o` on the next cycle. After the last byte is accepted, with nothing pending, `tx_valid_o` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Single-cycle request for one PAUSE frame |
| src_mac_i | input | 48 | Station address placed in the source field |
| pause_time_i | input | 16 | Pause duration in 512 bit-time quanta |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Byte on `tx_data_o` is valid |
| tx_ready_i | input | 1 | Downstream accepts the byte this cycle |
| tx_last_o | output | 1 | Current byte is the final check-sequence byte |

## Verification
Frames are built from several address and duration pairs: all-zero, all-ones, alternating bit patterns and an arbitrary value. This shows that each field sits at its own index and in the right byte order, and that the check sequence follows every data byte. The ready signal is driven always high, toggling, and high only one cycle in three, which separates correct stalling from dropped or repeated bytes. Directed cases change the operands in mid-frame and inject several requests during a frame; these tell apart capture at frame start from live sampling, and a merged pending request from lost or duplicated frames. A reset in mid-frame closes the tests.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  parameter int ADDR_W   = 48;
  parameter int PT_W     = 16;
  parameter int BYTE_W   = 8;
  parameter int BODY_LEN = 60;
  parameter int FCS_LEN  = 4;
  localparam int FRAME_LEN = BODY_LEN + FCS_LEN;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  localparam logic [ADDR_W-1:0] DEST_ADDR = 48'h0180_C200_0001;
  localparam logic [15:0]       CTL_TYPE  = 16'h8808;
  localparam logic [15:0]       PAUSE_OP  = 16'h0001;
  localparam logic [31:0]       CRC_POLY  = 32'hEDB8_8320;
  localparam logic [31:0]       CRC_SEED  = 32'hFFFF_FFFF;

  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/pfg_crc_step.sv
module pfg_crc_step
  import pfg_pkg::*;
(
  input  logic [31:0]       crc_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [31:0]       crc_o
);
  always_comb begin
    logic [31:0] acc;
    acc = crc_i ^ {24'd0, byte_i};
    for (int b = 0; b < BYTE_W; b++) begin
      acc = acc[0] ? ((acc >> 1) ^ CRC_POLY) : (acc >> 1);
    end
    crc_o = acc;
  end
endmodule

// File: rtl/pfg_byte_sel.sv
module pfg_byte_sel
  import pfg_pkg::*;
(
  input  idx_t              idx_i,
  input  logic [ADDR_W-1:0] mac_i,
  input  logic [PT_W-1:0]   pt_i,
  input  logic [31:0]       crc_i,
  output logic [BYTE_W-1:0] byte_o
);
  localparam idx_t SRC_AT  = idx_t'(6);
  localparam idx_t TYPE_AT = idx_t'(12);
  localparam idx_t OP_AT   = idx_t'(14);
  localparam idx_t PT_AT   = idx_t'(16);
  localparam idx_t PAD_AT  = idx_t'(18);
  localparam idx_t FCS_AT  = idx_t'(BODY_LEN);

  logic [31:0] fcs;
  idx_t        off;

  assign fcs = ~crc_i;

  always_comb begin
    byte_o = '0;
    off    = '0;
    if (idx_i < SRC_AT) begin
      off    = idx_i;
      byte_o = DEST_ADDR[ADDR_W-1-8*off[2:0] -: 8];
    end else if (idx_i < TYPE_AT) begin
      off    = idx_i - SRC_AT;
      byte_o = mac_i[ADDR_W-1-8*off[2:0] -: 8];
    end else if (idx_i < OP_AT) begin
      off    = idx_i - TYPE_AT;
      byte_o = off[0] ? CTL_TYPE[7:0] : CTL_TYPE[15:8];
    end else if (idx_i < PT_AT) begin
      off    = idx_i - OP_AT;
      byte_o = off[0] ? PAUSE_OP[7:0] : PAUSE_OP[15:8];
    end else if (idx_i < PAD_AT) begin
      off    = idx_i - PT_AT;
      byte_o = off[0] ? pt_i[7:0] : pt_i[15:8];
    end else if (idx_i >= FCS_AT) begin
      off    = idx_i - FCS_AT;
      byte_o = fcs[8*off[1:0] +: 8];
    end
  end
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] src_mac_i,
  input  logic [PT_W-1:0]   pause_time_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              tx_last_o
);
  localparam idx_t LAST_IDX = idx_t'(FRAME_LEN - 1);
  localparam idx_t BODY_END = idx_t'(BODY_LEN);

  logic              busy_q, busy_d;
  logic              pend_q, pend_d;
  idx_t              idx_q, idx_d;
  logic [ADDR_W-1:0] mac_q;
  logic [PT_W-1:0]   pt_q;
  logic [31:0]       crc_q, crc_d, crc_upd;
  logic              fire, done, start;

  pfg_byte_sel sel_i (
    .idx_i (idx_q),
    .mac_i (mac_q),
    .pt_i  (pt_q),
    .crc_i (crc_q),
    .byte_o(tx_data_o)
  );

  pfg_crc_step crc_i (
    .crc_i (crc_q),
    .byte_i(tx_data_o),
    .crc_o (crc_upd)
  );

  assign tx_valid_o = busy_q;
  assign tx_last_o  = busy_q & (idx_q == LAST_IDX);

  always_comb begin
    fire   = busy_q & tx_ready_i;
    done   = fire & (idx_q == LAST_IDX);
    start  = (~busy_q & req_i) | (done & (pend_q | req_i));
    busy_d = busy_q;
    idx_d  = idx_q;
    crc_d  = crc_q;
    pend_d = pend_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      crc_d  = CRC_SEED;
      pend_d = 1'b0;
    end else begin
      if (done) busy_d = 1'b0;
      if (fire) idx_d = idx_q + idx_t'(1);
      if (fire && (idx_q < BODY_END)) crc_d = crc_upd;
      if (busy_q && req_i) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      idx_q  <= '0;
      crc_q  <= CRC_SEED;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      idx_q  <= idx_d;
      crc_q  <= crc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_q <= '0;
      pt_q  <= '0;
    end else if (start) begin
      mac_q <= src_mac_i;
      pt_q  <= pause_time_i;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

  // R8
  last_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last_o |-> tx_valid_o);

  // R12
  rise_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid_o) |-> $past(req_i));

  // R12
  drop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last_o && tx_ready_i && !pend_q && !req_i) |=> !tx_valid_o);

  // R10
  pend_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last_o && tx_ready_i && pend_q) |=> (tx_valid_o && !tx_last_o));

  // R11
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && $past(tx_valid_o) && !$past(tx_last_o)) |-> ($stable(mac_q) && $stable(pt_q)));
endmodule

// File: tb/pause_frame_gen_tb.sv
module pause_frame_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req;
  logic [47:0] mac;
  logic [15:0] ptime;
  logic [7:0]  data;
  logic        valid;
  logic        ready;
  logic        last;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_b [64];

  pause_frame_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .src_mac_i   (mac),
    .pause_time_i(ptime),
    .tx_data_o   (data),
    .tx_valid_o  (valid),
    .tx_ready_i  (ready),
    .tx_last_o   (last)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: {address, duration, ready mode}; modes 0 always, 1 toggling, 2 one in three
  localparam logic [65:0] VEC [5] = '{
    {48'h0000_0000_0000, 16'h0000, 2'd0},
    {48'hFFFF_FFFF_FFFF, 16'hFFFF, 2'd1},
    {48'hA5A5_5A5A_A5A5, 16'h0680, 2'd2},
    {48'h0012_3456_789A, 16'h5AA5, 2'd0},
    {48'h5555_AAAA_5555, 16'h0001, 2'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic build_exp(input logic [47:0] a, input logic [15:0] p);
    logic [47:0] dst;
    logic [31:0] c;
    dst = 48'h0180_C200_0001;
    for (int i = 0; i < 6; i++) begin
      exp_b[i]     = dst[47-8*i -: 8];
      exp_b[6 + i] = a[47-8*i -: 8];
    end
    exp_b[12] = 8'h88; exp_b[13] = 8'h08;
    exp_b[14] = 8'h00; exp_b[15] = 8'h01;
    exp_b[16] = p[15:8]; exp_b[17] = p[7:0];
    for (int i = 18; i < 60; i++) exp_b[i] = 8'h00;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 60; i++) begin
      c = c ^ {24'd0, exp_b[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) exp_b[60 + i] = c[8*i +: 8];
  endtask

  function automatic string tag_of(input int i);
    if (i < 6)  return "R2";
    if (i < 12) return "R3";
    if (i < 16) return "R4";
    if (i < 18) return "R5";
    if (i < 60) return "R6";
    return "R7";
  endfunction

  // action 0 none, 1 scramble operands mid-frame, 2 inject requests with new operands
  task automatic recv_frame(input int mode, input int action,
                            input logic [47:0] na, input logic [15:0] np);
    int   got = 0;
    int   cyc = 0;
    logic stalled = 1'b0;
    logic [7:0] held = '0;
    while (got < 64 && cyc < 2000) begin
      @(negedge clk);
      req = 1'b0;
      case (mode)
        0: ready = 1'b1;
        1: ready = cyc[0];
        default: ready = (cyc % 3 == 2);
      endcase
      cyc++;
      #1;
      if (stalled) begin
        check("R9 valid held", {31'd0, valid}, 32'd1);
        check("R9 data held", {24'd0, data}, {24'd0, held});
      end
      stalled = valid && !ready;
      held = data;
      if (valid && ready) begin
        check(tag_of(got), {24'd0, data}, {24'd0, exp_b[got]});
        check("R8 last", {31'd0, last}, {31'd0, (got == 63)});
        if (action == 1 && got == 20) begin
          mac = ~mac; ptime = ~ptime;
        end
        if (action == 2 && (got == 10 || got == 30)) begin
          req = 1'b1; mac = na; ptime = np;
        end
        got++;
      end
    end
    check("R8 frame length", got, 64);
  endtask

  task automatic idle_check();
    @(negedge clk);
    req = 1'b0;
    ready = 1'b1;
    #1;
    check("R12 valid falls", {31'd0, valid}, 32'd0);
  endtask

  task automatic fire_req(input logic [47:0] a, input logic [15:0] p);
    @(negedge clk);
    req = 1'b1; mac = a; ptime = p; ready = 1'b0;
    @(negedge clk);
    req = 1'b0;
    #1;
    check("R12 valid rises", {31'd0, valid}, 32'd1);
  endtask

  initial begin
    int unsigned cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=<50000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [47:0] a;
    logic [15:0] p;
    rst_n = 1'b0; req = 1'b0; ready = 1'b0; mac = '0; ptime = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 valid in reset", {31'd0, valid}, 32'd0);
    check("R1 last in reset", {31'd0, last}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 valid after reset", {31'd0, valid}, 32'd0);

    for (int v = 0; v < 5; v++) begin
      a = VEC[v][65:18];
      p = VEC[v][17:2];
      build_exp(a, p);
      fire_req(a, p);
      recv_frame(int'(VEC[v][1:0]), 0, '0, '0);
      idle_check();
    end

    // R11: operands change mid-frame, frame keeps captured values
    a = 48'h0203_0405_0607; p = 16'h1234;
    build_exp(a, p);
    fire_req(a, p);
    recv_frame(1, 1, '0, '0);
    idle_check();

    // R10: two requests during a frame merge into one follow-on frame
    a = 48'h0A0B_0C0D_0E0F; p = 16'hFFFF;
    build_exp(a, p);
    fire_req(a, p);
    recv_frame(2, 2, 48'h1122_3344_5566, 16'h0000);
    build_exp(48'h1122_3344_5566, 16'h0000);
    #1;
    check("R10 back-to-back start", {31'd0, valid}, 32'd1);
    recv_frame(0, 0, '0, '0);
    idle_check();

    // R1: reset in mid-frame
    fire_req(48'h0, 16'h0);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 valid mid-frame reset", {31'd0, valid}, 32'd0);
    check("R1 last mid-frame reset", {31'd0, last}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 idle after reset", {31'd0, valid}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule